// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a clocked request port to a 16-bit asynchronous static RAM. A client asks for one read or write at a time. Each request carries a word address, write data and a per-byte skip mask. The controller turns the request into chip-select, write-strobe, output-strobe and byte-lane pin activity. Each strobe is held for a whole number of clock cycles, chosen by a parameter so that the memory's 12 ns access and cycle time is met. Read data comes back on a one-cycle valid pulse. Skipped byte lanes read as zero.

The bidirectional data bus appears as separate out, in and drive-enable signals. The controller drives the bus only while writing. Before a write that follows a read, it adds a one-cycle gap with the driver off. After reset it refuses requests for a parameterised hold-off, which covers the memory's 100 µs start-up wait. A standby input deselects the memory. After standby is released, the controller waits a recovery interval before it accepts the next access.

Top module: `sram_async_ctrl`

## Requirements
- R1: The memory counts as selected only when `mem_sel_n` is 0 and `mem_sel` is 1. Both strobes (`mem_we_n`, `mem_oe_n`) are driven low only while the memory is selected. During power-up hold-off and standby, `mem_sel_n`=1 and `mem_sel`=0.
- R2: An accepted write with at least one lane enabled drives `mem_we_n` low for exactly ACCESS_CYC consecutive cycles. `mem_lane_n[i]` equals `req_mask[i]`, where bit 0 is data bits 7:0 and bit 1 is data bits 15:8. A mask bit of 1 skips that lane. Only the enabled lanes of the addressed word change.
- R3: An accepted read drives `mem_oe_n` low with `mem_we_n` high for ACCESS_CYC cycles. `rd_valid` pulses for one cycle, ACCESS_CYC clock edges after the accepting edge. In `rd_data`, enabled lanes carry the memory data and skipped lanes read as 0.
- R4: `mem_dq_oe` is high only during write activity and is never high while `mem_oe_n` is low.
- R5: A write that follows a read starts driving the bus no earlier than three cycles after the last cycle with `mem_oe_n` low. This leaves one idle cycle plus one turnaround cycle with the driver off.
- R6: `mem_addr` and `mem_dq_out` stay stable while `mem_we_n` is low and in the cycle in which `mem_we_n` returns high.
- R7: A request whose mask is all ones completes without any strobe. For a read, `rd_valid` pulses at the accepting edge with `rd_data`=0. For both reads and writes, `req_ready` stays high.
- R8: After reset is released, `req_ready` stays low for exactly PWRUP_CYC clock edges.
- R9: While `stby_req` is high and the controller is idle, the memory is deselected and `req_ready` is low. After `stby_req` falls, `req_ready` returns after RECOV_CYC+1 clock edges. Memory contents are preserved.
- R10: `req_ready` is high only when no access is in progress, so requests are serviced one at a time in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stby_req | input | 1 | Request standby deselection |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Per-lane skip mask, 1 = lane skipped |
| rd_data | output | DATA_W | Read data, skipped lanes zero |
| rd_valid | output | 1 | One-cycle read-data valid |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lane_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_in | input | DATA_W | Data returned by the memory |
| mem_dq_oe | output | 1 | Data-bus driver enable |

## Verification
The bench connects a small behavioural memory and sweeps every address of a reduced array against every lane mask. Writes and reads are interleaved, so each write follows a read. A controller without the turnaround gap would drive the bus one cycle after the memory released it. A controller that latched skipped lanes, or sampled before the output strobe, would return the memory model's filler byte 0xA5 instead of zero or the stored data. Strobe widths, address and data hold around the rising write strobe, the exact power-up and recovery counts, and the strobe-free completion of all-skipped requests are all measured at the pins. An off-by-one counter, an early address change, or a spurious strobe would each show up as a counted mismatch.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int ACCESS_CYC = 2,
  parameter int PWRUP_CYC  = 10000,
  parameter int RECOV_CYC  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stby_req,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  mem_sel_n,
  output logic                  mem_sel,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_lane_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_dq_out,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic                  mem_dq_oe
);

  localparam int LANES = DATA_W / 8;
  localparam int MAXC  = (PWRUP_CYC > ACCESS_CYC) ?
                         ((PWRUP_CYC > RECOV_CYC) ? PWRUP_CYC : RECOV_CYC) :
                         ((ACCESS_CYC > RECOV_CYC) ? ACCESS_CYC : RECOV_CYC);
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_PWR, S_IDLE, S_STBY, S_REC, S_TURN, S_WR, S_WHLD, S_RD
  } state_t;

  state_t              st;
  logic [CW-1:0]       cnt;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    mask_q;
  logic                last_rd;
  logic [DATA_W-1:0]   rd_lanes;

  wire accept   = req_valid && req_ready;
  wire all_skip = &req_mask;
  wire cnt_done = (cnt == '0);
  wire strobing = (st == S_WR) || (st == S_RD);

  assign req_ready  = (st == S_IDLE) && !stby_req;
  assign mem_sel_n  = (st == S_PWR) || (st == S_STBY) || (st == S_REC);
  assign mem_sel    = !mem_sel_n;
  assign mem_we_n   = (st != S_WR);
  assign mem_oe_n   = (st != S_RD);
  assign mem_lane_n = strobing ? mask_q : {LANES{1'b1}};
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (st == S_WR) || (st == S_WHLD);

  always_comb begin
    for (int i = 0; i < LANES; i++)
      rd_lanes[i*8 +: 8] = mask_q[i] ? 8'h00 : mem_dq_in[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_PWR;
      cnt      <= CW'(PWRUP_CYC - 1);
      addr_q   <= '0;
      wdata_q  <= '0;
      mask_q   <= '1;
      last_rd  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_PWR: begin
          if (cnt_done) st <= S_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        S_IDLE: begin
          if (stby_req) begin
            st <= S_STBY;
          end else if (accept) begin
            if (all_skip) begin
              if (!req_write) begin
                rd_valid <= 1'b1;
                rd_data  <= '0;
              end
            end else begin
              addr_q  <= req_addr;
              wdata_q <= req_wdata;
              mask_q  <= req_mask;
              cnt     <= CW'(ACCESS_CYC - 1);
              if (!req_write)   st <= S_RD;
              else if (last_rd) st <= S_TURN;
              else              st <= S_WR;
            end
          end
        end
        S_STBY: begin
          if (!stby_req) begin
            st  <= S_REC;
            cnt <= CW'(RECOV_CYC - 1);
          end
        end
        S_REC: begin
          if (cnt_done) st <= S_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        S_TURN: st <= S_WR;
        S_WR: begin
          if (cnt_done) st <= S_WHLD;
          else          cnt <= cnt - 1'b1;
        end
        S_WHLD: begin
          st      <= S_IDLE;
          last_rd <= 1'b0;
        end
        S_RD: begin
          if (cnt_done) begin
            st       <= S_IDLE;
            rd_valid <= 1'b1;
            rd_data  <= rd_lanes;
            last_rd  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_strobe_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_sel_n && mem_sel));

  assert_no_bus_fight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));

  assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_skip_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mem_lane_n) |-> (mem_we_n && mem_oe_n));

  assert_standby_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stby_req |-> !req_ready);

  assert_single_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n || mem_dq_oe) |-> !req_ready);

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
  localparam int AW = 4, DW = 16, AC = 2, PU = 20, RC = 3;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0, stby_req = 0, req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rd_valid, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [1:0] mem_lane_n;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_bad = 0, cyc = 0, strobes = 0;
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] ref_m [NW];

  always #5 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(AC), .PWRUP_CYC(PU), .RECOV_CYC(RC)) i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  wire selected = !mem_sel_n && mem_sel;
  wire driving  = selected && !mem_oe_n && mem_we_n;
  assign mem_dq_in = { (driving && !mem_lane_n[1]) ? mem[mem_addr][15:8] : 8'hA5,
                       (driving && !mem_lane_n[0]) ? mem[mem_addr][7:0]  : 8'hA5 };

  always @(posedge clk) begin
    if (selected && !mem_we_n) begin
      if (!mem_lane_n[0]) mem[mem_addr][7:0]  <= mem_dq_out[7:0];
      if (!mem_lane_n[1]) mem[mem_addr][15:8] <= mem_dq_out[15:8];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // pin monitor, sampled at negedge
  int wlen = 0, since_rd = 100;
  logic prev_we = 1, prev_oe_dq = 0;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!mem_we_n || !mem_oe_n) begin
        strobes++;
        check("R1 strobe while selected", {mem_sel_n, mem_sel}, 2'b01);
      end
      if (mem_dq_oe && !mem_oe_n) check("R4 driver off during read", 1, 0);
      if (mem_dq_oe && !prev_oe_dq) check("R5 turnaround gap", (since_rd >= 3), 1);
      if (!mem_we_n) begin
        if (prev_we) begin w_addr = mem_addr; w_data = mem_dq_out; wlen = 0; end
        wlen++;
        if (mem_addr !== w_addr || mem_dq_out !== w_data) check("R6 hold during strobe", 1, 0);
      end else if (!prev_we) begin
        check("R2 write strobe width", wlen, AC);
        check("R6 hold after strobe", {mem_addr, mem_dq_out}, {w_addr, w_data});
      end
      since_rd = !mem_oe_n ? 1 : since_rd + 1;
      prev_we = mem_we_n;
      prev_oe_dq = mem_dq_oe;
    end
  end

  task automatic access(input logic w, input int a, input logic [DW-1:0] d, input logic [1:0] m,
                        output logic [DW-1:0] got, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 0; got = '0;
    if (!w) begin
      while (!rd_valid && lat < 50) begin @(negedge clk); lat++; end
      got = rd_data;
      @(negedge clk);
      check("R3 single-cycle valid", rd_valid, 0);
    end
    if (m != 2'b11) for (int k = 0; k < 60 && !req_ready; k++) @(negedge clk);
    if (w) for (int i = 0; i < 2; i++) if (!m[i]) ref_m[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  function automatic logic [DW-1:0] masked(input logic [DW-1:0] v, input logic [1:0] m);
    return {m[1] ? 8'h00 : v[15:8], m[0] ? 8'h00 : v[7:0]};
  endfunction

  initial begin
    logic [DW-1:0] got;
    int lat, n, s0;
    for (int a = 0; a < NW; a++) begin mem[a] = '0; ref_m[a] = '0; end
    repeat (3) @(negedge clk);
    check("R1 reset deselect", {mem_sel_n, mem_sel, mem_dq_oe}, 3'b100);
    check("R8 reset not ready", req_ready, 0);
    rst_n = 1;
    n = 0;
    @(negedge clk);
    n++;
    while (!req_ready && n < 1000) begin
      if (mem_sel_n !== 1'b1 || mem_sel !== 1'b0) check("R1 deselect in hold-off", {mem_sel_n, mem_sel}, 2'b10);
      @(negedge clk); n++;
    end
    check("R8 power-up hold-off edges", n, PU);

    for (int a = 0; a < NW; a++) access(1, a, DW'(a * 16'h0F1D + 16'h3C5A), 2'b00, got, lat);
    for (int a = 0; a < NW; a++) begin
      access(0, a, '0, 2'b00, got, lat);
      check("R3 read full word", got, ref_m[a]);
      check("R3 read latency", lat, AC);
    end

    for (int a = 0; a < NW; a++)
      for (int m = 0; m < 4; m++) begin
        s0 = strobes;
        access(1, a, DW'(~(a * 16'h0F1D) + m * 16'h0101), 2'(m), got, lat);
        if (m == 3) begin
          check("R7 skipped write no strobe", strobes - s0, 0);
          check("R7 ready stays high", req_ready, 1);
        end
        access(0, a, '0, 2'b00, got, lat);
        check("R2 lane-masked write", got, ref_m[a]);
        s0 = strobes;
        access(0, a, '0, 2'(a % 4), got, lat);
        if (a % 4 == 3) begin
          check("R7 skipped read latency", lat, 0);
          check("R7 skipped read data", got, 0);
          check("R7 skipped read no strobe", strobes - s0, 0);
        end else begin
          check("R3 lane-masked read", got, masked(ref_m[a], 2'(a % 4)));
          check("R10 one access at a time latency", lat, AC);
        end
      end

    @(negedge clk);
    stby_req = 1;
    @(negedge clk);
    check("R9 standby deselect", {mem_sel_n, mem_sel, req_ready}, 3'b100);
    repeat (5) @(negedge clk);
    check("R9 standby held", {mem_sel_n, mem_sel, req_ready}, 3'b100);
    stby_req = 0;
    n = 0;
    @(negedge clk); n++;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    check("R9 recovery edges", n, RC + 1);
    for (int a = 0; a < NW; a += 5) begin
      access(0, a, '0, 2'b00, got, lat);
      check("R9 contents kept", got, ref_m[a]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule